// File: doc/BRIEF.md
# Multi-Format Signed Adder/Subtractor

This block adds or subtracts two k-bit signed operands held in any one of four binary codes: two's complement, one's complement, signed-magnitude and excess-B (biased). A two-bit select picks the code, and one control bit picks add or subtract. Both operands and the result use the chosen code.

Two flags come with each result. The carry flag reports that the stored bit patterns went out of unsigned range. The overflow flag reports that the signed value cannot be represented in the selected code. The flags are produced separately, so a carry can appear without an overflow and an overflow without a carry.

All outputs are registered. They take a new value one clock after an input strobe. Between strobes they hold their last value. The operand width is a parameter with a default of 8.

Top module: `multi_fmt_addsub`

## Requirements
- R1: With fmt_i = 0 (two's complement) the result is a + b when sub_i = 0, and a - b when sub_i = 1, both modulo 2^W.
- R2: In two's complement, ovf_o is high when the true signed result lies outside [-2^(W-1), 2^(W-1)-1]. carry_o is high when, read as unsigned numbers, a + b > 2^W-1 (add) or a < b (subtract). Each flag can be high while the other is low.
- R3: With fmt_i = 1 (one's complement) the carry out of the top bit is added back into bit 0. In this code negation is bit inversion. carry_o is that carry out, taken before it is added back, with b inverted for subtraction. ovf_o is high when the true result lies outside [-(2^(W-1)-1), 2^(W-1)-1]. On overflow the result is the wrapped one's complement sum.
- R4: In one's complement and signed-magnitude a zero result is always all zeros. Negative-zero operands (all ones, or only bit W-1 set) act as zero.
- R5: With fmt_i = 2 (signed-magnitude: bit W-1 is the sign, 1 means negative; bits W-2..0 are the magnitude), equal effective signs add the magnitudes and keep the sign. The effective sign of b is inverted when subtracting. A carry out of the magnitude field raises both carry_o and ovf_o, and the result is then undefined.
- R6: In signed-magnitude with opposite effective signs, the smaller magnitude is taken from the larger. The result takes the sign of the operand with the larger magnitude, and carry_o and ovf_o stay low.
- R7: With fmt_i = 3 (biased, B = 2^(W-1), code R stands for R - B), the result is the code of the true sum or difference. ovf_o is high when that value lies outside [-B, B-1], and the result is then undefined. carry_o reports unsigned out-of-range of the codes themselves: Ra + Rb > 2^W-1 when adding, Ra < Rb when subtracting.
- R8: valid_o rises one clock after a cycle with valid_i high and falls one clock after a cycle with valid_i low. res_o, carry_o and ovf_o change only one clock after a strobe and hold their value otherwise.
- R9: While rst_ni is low, valid_o, res_o, carry_o and ovf_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| fmt_i | input | 2 | Code select: 0 two's, 1 one's, 2 signed-magnitude, 3 biased |
| sub_i | input | 1 | 1 selects a - b, 0 selects a + b |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| valid_o | output | 1 | Result qualifier |
| res_o | output | W | Result in the selected code |
| carry_o | output | 1 | Unsigned out-of-range flag |
| ovf_o | output | 1 | Signed out-of-range flag |

## Verification
Directed pairs come first, for each code in turn. They cover mixed-sign sums that cancel to zero, same-sign sums that carry without overflowing, and sums that overflow without carrying. Together these show that the carry and overflow flags are generated separately. Negative-zero operands and exactly cancelling pairs test the end-around carry and the zero normalisation. Signed-magnitude pairs are given in both operand orders, so the sign must come from the larger magnitude and not from the first operand. Long runs of random operands, codes and operations, with idle gaps, then compare every cycle against a value-level model. The idle gaps test that the outputs hold between strobes.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    FMT_TWOS = 2'd0,
    FMT_ONES = 2'd1,
    FMT_SMAG = 2'd2,
    FMT_BIAS = 2'd3
  } num_fmt_e;
endpackage

// File: rtl/addsub_tc.sv
// Two's complement add/sub; bias_en_i re-biases for excess-2^(W-1) codes.
module addsub_tc #(
  parameter int W = 8
) (
  input  logic         bias_en_i,
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MsbMask = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_x;
  logic [W:0]   raw;
  logic         sgn_a, sgn_b;

  always_comb begin
    b_x     = b_i ^ {W{sub_i}};
    raw     = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
    // signs of the two's complement values behind the codes
    sgn_a   = a_i[W-1] ^ bias_en_i;
    sgn_b   = b_x[W-1] ^ bias_en_i;
    sum_o   = raw[W-1:0] ^ (bias_en_i ? MsbMask : '0);
    carry_o = raw[W] ^ sub_i;
    ovf_o   = (sgn_a == sgn_b) && (raw[W-1] != sgn_a);
  end
endmodule

// File: rtl/addsub_oc.sv
// One's complement add/sub with end-around carry and zero normalisation.
module addsub_oc #(
  parameter int W = 8
) (
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_x;
  logic [W:0]   raw;
  logic [W-1:0] eac;

  always_comb begin
    b_x     = b_i ^ {W{sub_i}};
    raw     = {1'b0, a_i} + {1'b0, b_x};
    eac     = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    carry_o = raw[W];
    ovf_o   = (a_i[W-1] == b_x[W-1]) && (eac[W-1] != a_i[W-1]);
    sum_o   = (&eac) ? '0 : eac;
  end
endmodule

// File: rtl/addsub_sm.sv
// Signed-magnitude add/sub: magnitude add or compare-and-subtract.
module addsub_sm #(
  parameter int W = 8
) (
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  localparam int MW = W - 1;

  logic [MW-1:0] mag_a, mag_b, mag_r, mag_d;
  logic [MW:0]   mag_s;
  logic          sgn_b, same, a_ge, sgn_r;

  always_comb begin
    mag_a   = a_i[MW-1:0];
    mag_b   = b_i[MW-1:0];
    sgn_b   = b_i[W-1] ^ sub_i;
    same    = (a_i[W-1] == sgn_b);
    mag_s   = {1'b0, mag_a} + {1'b0, mag_b};
    a_ge    = (mag_a >= mag_b);
    mag_d   = a_ge ? (mag_a - mag_b) : (mag_b - mag_a);
    mag_r   = same ? mag_s[MW-1:0] : mag_d;
    sgn_r   = (same || a_ge) ? a_i[W-1] : sgn_b;
    sum_o   = {sgn_r & (|mag_r), mag_r};
    carry_o = same & mag_s[MW];
    ovf_o   = same & mag_s[MW];
  end
endmodule

// File: rtl/multi_fmt_addsub.sv
module multi_fmt_addsub
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   fmt_i,
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         ovf_o
);
  num_fmt_e     fmt;
  logic [W-1:0] tc_sum, oc_sum, sm_sum;
  logic         tc_c, oc_c, sm_c, tc_v, oc_v, sm_v;
  logic [W-1:0] nxt_res;
  logic         nxt_c, nxt_v;

  assign fmt = num_fmt_e'(fmt_i);

  addsub_tc #(.W(W)) u_tc (
    .bias_en_i (fmt == FMT_BIAS),
    .sub_i     (sub_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .sum_o     (tc_sum),
    .carry_o   (tc_c),
    .ovf_o     (tc_v)
  );

  addsub_oc #(.W(W)) u_oc (
    .sub_i   (sub_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .sum_o   (oc_sum),
    .carry_o (oc_c),
    .ovf_o   (oc_v)
  );

  addsub_sm #(.W(W)) u_sm (
    .sub_i   (sub_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .sum_o   (sm_sum),
    .carry_o (sm_c),
    .ovf_o   (sm_v)
  );

  always_comb begin
    unique case (fmt)
      FMT_ONES: begin nxt_res = oc_sum; nxt_c = oc_c; nxt_v = oc_v; end
      FMT_SMAG: begin nxt_res = sm_sum; nxt_c = sm_c; nxt_v = sm_v; end
      default:  begin nxt_res = tc_sum; nxt_c = tc_c; nxt_v = tc_v; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      carry_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o   <= nxt_res;
        carry_o <= nxt_c;
        ovf_o   <= nxt_v;
      end
    end
  end
endmodule

// File: rtl/multi_fmt_addsub_chk.sv
module multi_fmt_addsub_chk
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [1:0]   fmt_i,
  input logic         sub_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         valid_o,
  input logic [W-1:0] res_o,
  input logic         carry_o,
  input logic         ovf_o
);
  localparam logic [W-1:0] NegZeroSm = {1'b1, {(W-1){1'b0}}};

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R8
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(carry_o) && $stable(ovf_o))); // R8
  AST_TC_OVF_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i == FMT_TWOS && !sub_i) |=>
      (ovf_o == (($past(a_i[W-1]) == $past(b_i[W-1])) && (res_o[W-1] != $past(a_i[W-1]))))); // R2
  AST_OC_NO_NEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i == FMT_ONES) |=> (res_o != '1)); // R4
  AST_SM_NO_NEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i == FMT_SMAG) |=> (res_o != NegZeroSm)); // R4
  AST_SM_SAME_CV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i == FMT_SMAG) |=> (carry_o == ovf_o)); // R5
  AST_SM_OPP_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i == FMT_SMAG && (a_i[W-1] != (b_i[W-1] ^ sub_i))) |=> (!carry_o && !ovf_o)); // R6
endmodule

bind multi_fmt_addsub multi_fmt_addsub_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .fmt_i   (fmt_i),
  .sub_i   (sub_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .valid_o (valid_o),
  .res_o   (res_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o)
);

// File: tb/multi_fmt_addsub_tb.sv
`timescale 1ns/1ps
module multi_fmt_addsub_tb;
  localparam int W   = 8;
  localparam int B   = 1 << (W - 1);
  localparam int M   = (1 << W) - 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   fmt_i = '0;
  logic         sub_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         valid_o, carry_o, ovf_o;
  logic [W-1:0] res_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // expected output state
  int    e_res = 0;
  bit    e_v = 0, e_c = 0, e_valid = 0, e_care = 0;
  string t_res = "R9", t_flg = "R9";

  always #2 clk_i = ~clk_i;

  multi_fmt_addsub #(.W(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .fmt_i(fmt_i),
    .sub_i(sub_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o),
    .res_o(res_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  function automatic int dec(int f, int x);
    case (f)
      0: return (x >= B) ? x - (M + 1) : x;
      1: return (x >= B) ? -((~x) & M) : x;
      2: return (x >= B) ? -(x - B) : x;
      default: return x - B;
    endcase
  endfunction

  task automatic model(int f, bit s, int a, int b);
    int va, vb, r, rr, bx, ma, mb;
    bit same;
    va = dec(f, a); vb = dec(f, b);
    r  = s ? va - vb : va + vb;
    e_care = 1;
    case (f)
      0: begin // R1 R2
        e_res = r & M;
        e_c = s ? (a < b) : (a + b > M);
        e_v = (r > B - 1) || (r < -B);
        t_res = "R1"; t_flg = "R2";
      end
      1: begin // R3
        bx = s ? ((~b) & M) : b;
        e_c = (a + bx) > M;
        e_v = (r > B - 1) || (r < -(B - 1));
        rr = r;
        if (r > B - 1) rr = r - M;
        if (r < -(B - 1)) rr = r + M;
        e_res = (rr >= 0) ? rr : ((~(-rr)) & M);
        t_res = "R3"; t_flg = "R3";
      end
      2: begin // R5 R6
        same = ((a >= B) ? 1'b1 : 1'b0) == (((b >= B) ? 1'b1 : 1'b0) ^ s);
        ma = a & (B - 1); mb = b & (B - 1);
        e_c = same && (ma + mb > B - 1);
        e_v = (r > B - 1) || (r < -(B - 1));
        e_res = (r >= 0) ? r : (B | (-r));
        e_care = !e_v;
        t_res = same ? "R5" : "R6"; t_flg = t_res;
      end
      default: begin // R7
        e_c = s ? (a < b) : (a + b > M);
        e_v = (r > B - 1) || (r < -B);
        e_res = (r + B) & M;
        e_care = !e_v;
        t_res = "R7"; t_flg = "R7";
      end
    endcase
    if ((f == 1 || f == 2) && e_care && e_res == 0) t_res = "R4";
  endtask

  task automatic chk(string tag, int got, int exp, string what);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compare();
    chk("R8", int'(valid_o), int'(e_valid), "valid_o");
    if (e_care) chk(t_res, int'(res_o), e_res, "res_o");
    chk(t_flg, int'(carry_o), int'(e_c), "carry_o");
    chk(t_flg, int'(ovf_o), int'(e_v), "ovf_o");
  endtask

  // one cycle: check outputs of the previous cycle, then drive new inputs
  task automatic step(bit v, int f, bit s, int a, int b);
    @(negedge clk_i);
    compare();
    valid_i = v; fmt_i = f[1:0]; sub_i = s; a_i = a[W-1:0]; b_i = b[W-1:0];
    e_valid = v;
    if (v) model(f, s, a, b);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9", int'(valid_o), 0, "valid_o");
    chk("R9", int'(res_o), 0, "res_o");
    chk("R9", int'(carry_o), 0, "carry_o");
    chk("R9", int'(ovf_o), 0, "ovf_o");
    rst_ni = 1'b1;
    // R8 encodings: fmt 0 two's, 1 one's, 2 sign-mag, 3 biased
    step(1, 0, 0, 'h05, 'hF6);   // R1 5 + -10
    step(1, 0, 0, 'hFB, 'hF6);   // R2 carry, no overflow
    step(1, 0, 0, 'h7F, 'h01);   // R2 overflow, no carry
    step(1, 0, 1, 'h00, 'h80);   // R2 overflow and borrow
    step(1, 0, 1, 'h80, 'h01);   // R2 overflow, no borrow
    step(0, 0, 0, 'h12, 'h34);   // R8 idle hold
    step(1, 1, 0, 'hFA, 'hF5);   // R3 end-around carry
    step(1, 1, 0, 'h0A, 'hFA);   // R3 10 + -5
    step(1, 1, 0, 'h05, 'hFA);   // R4 cancels to zero
    step(1, 1, 0, 'hFF, 'hFF);   // R4 -0 + -0
    step(1, 1, 1, 'h7F, 'hFE);   // R3 overflow
    step(1, 2, 0, 'h0B, 'h06);   // R5
    step(1, 2, 0, 'h8B, 'h06);   // R6 larger first
    step(1, 2, 0, 'h06, 'h8B);   // R6 larger second
    step(1, 2, 1, 'h05, 'h05);   // R4 zero
    step(1, 2, 0, 'h80, 'h80);   // R4 -0 + -0
    step(1, 2, 0, 'h7F, 'h01);   // R5 magnitude carry
    step(0, 2, 0, 'h00, 'h00);   // R8 idle
    step(1, 3, 0, 'h85, 'h83);   // R7 5 + 3
    step(1, 3, 0, 'h7F, 'h7E);   // R7 -1 + -2
    step(1, 3, 0, 'hFF, 'h81);   // R7 overflow
    step(1, 3, 1, 'h00, 'h01);   // R7 -128 - -127
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, $urandom % 4, $urandom % 2, $urandom % (M + 1), $urandom % (M + 1));
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R8 watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule